// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt request lines and picks one of them at each instruction boundary. There is one non-maskable line, three restart lines called high, mid and low, and one general request line. The winner is handed to the core as a one-cycle request pulse together with a 16-bit service address. The non-maskable, mid, low and general lines are level-sensed. The high restart line is edge-sensed through a latch that remembers a rising edge until that request is served or explicitly cleared.

The maskable sources are gated by a global enable flag and by per-line masks on the three restart lines. Accepting any request drops the enable flag. Software controls the block through an 8-bit control word on a mask-write strobe. That word loads the masks, clears the high-line latch and drives a one-bit serial output. A mask-read strobe captures an 8-bit status word holding the masks, the enable flag, the pending restart requests and a serial input bit.

The block is sequenced by a three-state machine:
- **IDLE** waits for the boundary strobe. On an accepted source it moves to **ISSUE**, or to **ACK** when the general line wins.
- **ACK** raises the general acknowledge and captures the externally supplied vector, then moves to **ISSUE**.
- **ISSUE** presents the request and vector for one cycle, then returns to **IDLE**.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is low and after it, `irq_o`, `gack_o`, `vec_o`, `status_o` and `serial_out_o` are 0. The enable flag resets to 0 and all three masks reset to 1, so the first mask read returns 0x07.
- R2: When several sources are accepted in the same boundary strobe, the order from highest to lowest is non-maskable, high restart, mid restart, low restart, general.
- R3: If `sample_i` is high in IDLE in cycle N and a source qualifies, `irq_o` is high for exactly cycle N+1 (N+2 for the general line). `vec_o` then carries 0x0024 for non-maskable, 0x003C for high, 0x0034 for mid and 0x002C for low. `vec_o` is 0 whenever `irq_o` is low.
- R4: The non-maskable line is accepted whenever it is high at a strobe, whatever the enable flag and masks hold.
- R5: Restart and general sources are accepted only while the enable flag is 1. `en_set_i` sets the flag and `en_clr_i` clears it, and when both are high together the clear wins.
- R6: Acceptance of any source clears the enable flag at the same clock edge, taking priority over `en_set_i`.
- R7: A rising edge on `rq_hi_i` sets a pending latch, even while that line is masked. The latch stays set after the line falls. It is cleared when the high source is accepted or when a control word with bit 4 set is written. A new edge wins over a clear in the same cycle. A line held high produces no second request.
- R8: The mid, low and general lines qualify only while they are high in the strobe cycle.
- R9: A control word with bit 3 set loads the masks from bits 2, 1 and 0 (high, mid, low; 1 means masked). A word with bit 3 clear leaves the masks unchanged.
- R10: A control word with bit 6 set loads `serial_out_o` from bit 7. A word with bit 6 clear leaves it unchanged.
- R11: `mask_rd_i` in cycle N makes `status_o` from cycle N+1 equal {serial input, high pending, mid line, low line, enable flag, high mask, mid mask, low mask}, bit 7 down to bit 0. Without a read, `status_o` holds.
- R12: When the general line wins, `gack_o` is high for exactly one cycle. `gvec_i` is sampled in that cycle and appears on `vec_o` with `irq_o` in the next cycle. `gack_o` and `irq_o` are never high together.
- R13: `sample_i` outside IDLE is ignored. A strobe held for two cycles over a non-maskable request yields one request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, level |
| rq_hi_i | input | 1 | High restart request, rising edge |
| rq_mid_i | input | 1 | Mid restart request, level |
| rq_lo_i | input | 1 | Low restart request, level |
| greq_i | input | 1 | General request, level |
| gvec_i | input | VEC_W | Vector supplied for the general request |
| sample_i | input | 1 | Instruction-boundary sample strobe |
| en_set_i | input | 1 | Set the enable flag |
| en_clr_i | input | 1 | Clear the enable flag |
| mask_wr_i | input | 1 | Apply `ctl_word_i` |
| ctl_word_i | input | 8 | Control word |
| mask_rd_i | input | 1 | Capture the status word |
| serial_in_i | input | 1 | Serial input bit for the status word |
| irq_o | output | 1 | One-cycle interrupt request |
| vec_o | output | VEC_W | Service address, valid with `irq_o` |
| gack_o | output | 1 | General request acknowledge |
| status_o | output | 8 | Captured status word |
| serial_out_o | output | 1 | Serial output bit |

## Verification
The properties assume `sample_i` marks real boundaries and that the non-maskable line, when used, is held through the acceptance cycle. Under that assumption the vector that follows can be tied to the line's value at the strobe. The properties also assume the external vector is stable in the acknowledge cycle. The bench drives every input at the falling edge and keeps the level lines steady across each strobe. It produces edges on the high line by explicit low-high-low pulses after reset, so the edge latch never sees a stale level from before reset.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int CW_W       = 8;
    localparam int NRST       = 3;

    // Control word field positions
    localparam int CW_SER_BIT = 7;
    localparam int CW_SER_EN  = 6;
    localparam int CW_HI_CLR  = 4;
    localparam int CW_MSK_EN  = 3;

    // Restart line indices inside mask / pending vectors
    localparam int IDX_HI     = 2;
    localparam int IDX_MID    = 1;
    localparam int IDX_LO     = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_ISSUE
    } fsm_state_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_HI,
        SRC_MID,
        SRC_LO,
        SRC_GEN
    } src_t;

endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);

    logic line_q;
    logic rise;

    assign rise = line_i & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            line_q <= line_i;
            if (rise) begin
                pend_o <= 1'b1;
            end else if (clr_i) begin
                pend_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/intc_ctl_regs.sv
module intc_ctl_regs
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_set_i,
    input  logic            en_clr_i,
    input  logic            accept_i,
    input  logic            mask_wr_i,
    input  logic [CW_W-1:0] ctl_word_i,
    input  logic            mask_rd_i,
    input  logic            serial_in_i,
    input  logic [NRST-1:0] pend_i,
    output logic            ie_o,
    output logic [NRST-1:0] mask_o,
    output logic            serial_out_o,
    output logic [CW_W-1:0] status_o
);

    logic       load_mask;
    logic       load_ser;
    logic [1:0] unused_word_bits;

    assign load_mask        = mask_wr_i & ctl_word_i[CW_MSK_EN];
    assign load_ser         = mask_wr_i & ctl_word_i[CW_SER_EN];
    assign unused_word_bits = ctl_word_i[5:4];

    // Enable flag: acceptance beats clear beats set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_o <= 1'b0;
        end else if (accept_i || en_clr_i) begin
            ie_o <= 1'b0;
        end else if (en_set_i) begin
            ie_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (load_mask) begin
            mask_o <= ctl_word_i[NRST-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_out_o <= 1'b0;
        end else if (load_ser) begin
            serial_out_o <= ctl_word_i[CW_SER_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (mask_rd_i) begin
            status_o <= {serial_in_i, pend_i, ie_o, mask_o};
        end
    end

endmodule

// File: rtl/intc_fsm.sv
module intc_fsm
    import intc_pkg::*;
#(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'('h0024),
    parameter logic [VEC_W-1:0] HI_VEC  = VEC_W'('h003C),
    parameter logic [VEC_W-1:0] MID_VEC = VEC_W'('h0034),
    parameter logic [VEC_W-1:0] LO_VEC  = VEC_W'('h002C)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             nmi_i,
    input  logic             ie_i,
    input  logic [NRST-1:0]  armed_i,
    input  logic             greq_i,
    input  logic [VEC_W-1:0] gvec_i,
    output logic             accept_o,
    output logic             take_hi_o,
    output logic             irq_o,
    output logic             gack_o,
    output logic [VEC_W-1:0] vec_o
);

    fsm_state_t       state_q, state_d;
    src_t             win;
    logic [VEC_W-1:0] vec_q;

    function automatic logic [VEC_W-1:0] vec_of(input src_t s);
        case (s)
            SRC_NMI: vec_of = NMI_VEC;
            SRC_HI:  vec_of = HI_VEC;
            SRC_MID: vec_of = MID_VEC;
            SRC_LO:  vec_of = LO_VEC;
            default: vec_of = '0;
        endcase
    endfunction

    // Fixed-priority resolution
    always_comb begin
        if (nmi_i) begin
            win = SRC_NMI;
        end else if (ie_i && armed_i[IDX_HI]) begin
            win = SRC_HI;
        end else if (ie_i && armed_i[IDX_MID]) begin
            win = SRC_MID;
        end else if (ie_i && armed_i[IDX_LO]) begin
            win = SRC_LO;
        end else if (ie_i && greq_i) begin
            win = SRC_GEN;
        end else begin
            win = SRC_NONE;
        end
    end

    assign accept_o  = (state_q == ST_IDLE) && sample_i && (win != SRC_NONE);
    assign take_hi_o = accept_o && (win == SRC_HI);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d = (win == SRC_GEN) ? ST_ACK : ST_ISSUE;
                end
            end
            ST_ACK:   state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Vector register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (accept_o) begin
            vec_q <= vec_of(win);
        end else if (state_q == ST_ACK) begin
            vec_q <= gvec_i;
        end
    end

    // Outputs
    always_comb begin
        irq_o  = 1'b0;
        gack_o = 1'b0;
        vec_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  gack_o = 1'b1;
            ST_ISSUE: begin
                irq_o = 1'b1;
                vec_o = vec_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'('h0024),
    parameter logic [VEC_W-1:0] HI_VEC  = VEC_W'('h003C),
    parameter logic [VEC_W-1:0] MID_VEC = VEC_W'('h0034),
    parameter logic [VEC_W-1:0] LO_VEC  = VEC_W'('h002C)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_i,
    input  logic             rq_hi_i,
    input  logic             rq_mid_i,
    input  logic             rq_lo_i,
    input  logic             greq_i,
    input  logic [VEC_W-1:0] gvec_i,
    input  logic             sample_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             mask_wr_i,
    input  logic [7:0]       ctl_word_i,
    input  logic             mask_rd_i,
    input  logic             serial_in_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             gack_o,
    output logic [7:0]       status_o,
    output logic             serial_out_o
);

    logic            hi_pend_w;
    logic            hi_clr_w;
    logic            take_hi_w;
    logic            accept_w;
    logic            ie_w;
    logic [NRST-1:0] mask_w;
    logic [NRST-1:0] pend_w;
    logic [NRST-1:0] armed_w;

    assign hi_clr_w = take_hi_w | (mask_wr_i & ctl_word_i[CW_HI_CLR]);
    assign pend_w   = {hi_pend_w, rq_mid_i, rq_lo_i};

    generate
        for (genvar g = 0; g < NRST; g++) begin : g_arm
            assign armed_w[g] = pend_w[g] & ~mask_w[g];
        end
    endgenerate

    intc_edge_latch u_hi_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rq_hi_i),
        .clr_i  (hi_clr_w),
        .pend_o (hi_pend_w)
    );

    intc_ctl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set_i     (en_set_i),
        .en_clr_i     (en_clr_i),
        .accept_i     (accept_w),
        .mask_wr_i    (mask_wr_i),
        .ctl_word_i   (ctl_word_i),
        .mask_rd_i    (mask_rd_i),
        .serial_in_i  (serial_in_i),
        .pend_i       (pend_w),
        .ie_o         (ie_w),
        .mask_o       (mask_w),
        .serial_out_o (serial_out_o),
        .status_o     (status_o)
    );

    intc_fsm #(
        .VEC_W   (VEC_W),
        .NMI_VEC (NMI_VEC),
        .HI_VEC  (HI_VEC),
        .MID_VEC (MID_VEC),
        .LO_VEC  (LO_VEC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .nmi_i     (nmi_i),
        .ie_i      (ie_w),
        .armed_i   (armed_w),
        .greq_i    (greq_i),
        .gvec_i    (gvec_i),
        .accept_o  (accept_w),
        .take_hi_o (take_hi_w),
        .irq_o     (irq_o),
        .gack_o    (gack_o),
        .vec_o     (vec_o)
    );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'('h0024)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nmi_i,
    input logic             mask_wr_i,
    input logic [7:0]       ctl_word_i,
    input logic             mask_rd_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             gack_o,
    input logic [7:0]       status_o,
    input logic             serial_out_o,
    input logic             accept,
    input logic             ie
);

    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_vec_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));

    p_nmi_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && nmi_i) |=> (irq_o && vec_o == NMI_VEC));

    p_accept_drops_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ie);

    p_ser_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr_i && ctl_word_i[6]) |=> $stable(serial_out_o));

    p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rd_i |=> $stable(status_o));

    p_ack_then_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        gack_o |=> (irq_o && !gack_o));

    p_ack_irq_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gack_o && irq_o));

endmodule

bind prio_vec_intc intc_checker #(
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_i        (nmi_i),
    .mask_wr_i    (mask_wr_i),
    .ctl_word_i   (ctl_word_i),
    .mask_rd_i    (mask_rd_i),
    .irq_o        (irq_o),
    .vec_o        (vec_o),
    .gack_o       (gack_o),
    .status_o     (status_o),
    .serial_out_o (serial_out_o),
    .accept       (accept_w),
    .ie           (ie_w)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 0, rq_hi = 0, rq_mid = 0, rq_lo = 0, greq = 0;
    logic [15:0] gvec = 16'h0000;
    logic        sample = 0, en_set = 0, en_clr = 0, mwr = 0, mrd = 0, sin = 0;
    logic [7:0]  word = 8'h00;
    logic        irq_o, gack_o, sout_o;
    logic [15:0] vec_o;
    logic [7:0]  status_o;

    prio_vec_intc u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_i        (nmi),
        .rq_hi_i      (rq_hi),
        .rq_mid_i     (rq_mid),
        .rq_lo_i      (rq_lo),
        .greq_i       (greq),
        .gvec_i       (gvec),
        .sample_i     (sample),
        .en_set_i     (en_set),
        .en_clr_i     (en_clr),
        .mask_wr_i    (mwr),
        .ctl_word_i   (word),
        .mask_rd_i    (mrd),
        .serial_in_i  (sin),
        .irq_o        (irq_o),
        .vec_o        (vec_o),
        .gack_o       (gack_o),
        .status_o     (status_o),
        .serial_out_o (sout_o)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int n_irq = 0;
    logic [15:0] last_vec = 16'h0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reference model: phase 0 idle, 1 acknowledge, 2 issue
    int          m_phase;
    bit          m_ie, m_latch, m_prev, m_sod;
    bit [2:0]    m_mask;
    bit [7:0]    m_status;
    bit [15:0]   m_vec;
    int          t_w;
    bit          t_rise;

    function automatic bit [15:0] vec_for(input int w);
        case (w)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ie = 0; m_latch = 0; m_prev = 0; m_sod = 0;
            m_mask = 3'b111; m_status = 8'h00; m_vec = 16'h0;
        end else begin
            t_w = 0;
            if (m_phase == 0 && sample) begin
                if (nmi) t_w = 1;
                else if (m_ie && m_latch && !m_mask[2]) t_w = 2;
                else if (m_ie && rq_mid && !m_mask[1]) t_w = 3;
                else if (m_ie && rq_lo && !m_mask[0]) t_w = 4;
                else if (m_ie && greq) t_w = 5;
            end
            if (mrd) m_status = {sin, m_latch, rq_mid, rq_lo, m_ie, m_mask};
            t_rise = rq_hi && !m_prev;
            if (t_rise) m_latch = 1;
            else if (t_w == 2 || (mwr && word[4])) m_latch = 0;
            m_prev = rq_hi;
            if (t_w != 0) m_ie = 0;
            else if (en_clr) m_ie = 0;
            else if (en_set) m_ie = 1;
            if (mwr && word[3]) m_mask = word[2:0];
            if (mwr && word[6]) m_sod = word[7];
            case (m_phase)
                0: begin
                    if (t_w == 5) m_phase = 1;
                    else if (t_w != 0) begin m_phase = 2; m_vec = vec_for(t_w); end
                end
                1: begin m_vec = gvec; m_phase = 2; end
                default: m_phase = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 irq_o", irq_o, m_phase == 2);
            chk("R3 vec_o", vec_o, (m_phase == 2) ? m_vec : 16'h0);
            chk("R12 gack_o", gack_o, m_phase == 1);
            chk("R10 serial_out_o", sout_o, m_sod);
            chk("R11 status_o", status_o, m_status);
            if (irq_o) begin
                n_irq++;
                last_vec = vec_o;
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_sample();
        sample = 1; step(); sample = 0;
        step(); step(); step();
    endtask

    task automatic wr_word(input logic [7:0] w);
        word = w; mwr = 1; step(); mwr = 0; word = 8'h00;
    endtask

    task automatic rd_status();
        mrd = 1; step(); mrd = 0;
    endtask

    task automatic do_ei();
        en_set = 1; step(); en_set = 0;
    endtask

    task automatic hi_pulse();
        rq_hi = 1; step(); rq_hi = 0; step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (3) step();
        // R1: outputs quiet in reset
        chk("R1 irq in reset", irq_o, 0);
        chk("R1 gack in reset", gack_o, 0);
        chk("R1 vec in reset", vec_o, 0);
        chk("R1 status in reset", status_o, 0);
        chk("R1 serial in reset", sout_o, 0);
        rst_n = 1;
        step();
        rd_status();
        chk("R1 masks set, enable clear", status_o, 8'h07);

        // R4: non-maskable with enable off
        nmi = 1; pulse_sample(); nmi = 0;
        chk("R4 nmi count", n_irq, 1);
        chk("R4 nmi vector", last_vec, 16'h0024);

        // R5 / R8 / R9: low line gated by masks then by enable
        rq_lo = 1;
        pulse_sample();
        chk("R5 masked and disabled", n_irq, 1);
        wr_word(8'h08);
        pulse_sample();
        chk("R5 unmasked but disabled", n_irq, 1);
        do_ei();
        pulse_sample();
        chk("R8 low accepted", n_irq, 2);
        chk("R9 low vector", last_vec, 16'h002C);
        rd_status();
        chk("R6 enable dropped after accept", status_o, 8'h10);
        pulse_sample();
        chk("R6 no second accept", n_irq, 2);
        rq_lo = 0;

        // R2: priority walk
        rq_mid = 1; rq_lo = 1; greq = 1;
        hi_pulse();
        do_ei(); pulse_sample();
        chk("R2 high wins", last_vec, 16'h003C);
        chk("R7 latch held after fall", n_irq, 3);
        do_ei(); pulse_sample();
        chk("R2 mid next", last_vec, 16'h0034);
        rq_mid = 0;
        do_ei(); pulse_sample();
        chk("R2 low next", last_vec, 16'h002C);
        rq_lo = 0; gvec = 16'hA5F0;
        do_ei(); pulse_sample();
        chk("R12 general vector", last_vec, 16'hA5F0);
        chk("R12 general count", n_irq, 6);
        greq = 0;

        // R7: latch under mask, explicit clear, no retrigger
        wr_word(8'h0C);
        hi_pulse();
        do_ei(); pulse_sample();
        chk("R7 masked high not taken", n_irq, 6);
        rd_status();
        chk("R7 pending while masked", status_o, 8'h4C);
        wr_word(8'h18);
        rd_status();
        chk("R7 cleared by word bit4", status_o, 8'h08);
        pulse_sample();
        chk("R9 cleared latch not taken", n_irq, 6);
        rq_hi = 1; step();
        pulse_sample();
        chk("R7 edge accepted", last_vec, 16'h003C);
        chk("R7 edge count", n_irq, 7);
        do_ei(); pulse_sample();
        chk("R7 held line no retrigger", n_irq, 7);
        rq_hi = 0; step();

        // R10: serial output
        wr_word(8'hC0);
        chk("R10 serial set", sout_o, 1);
        wr_word(8'h80);
        chk("R10 serial held", sout_o, 1);
        wr_word(8'h40);
        chk("R10 serial cleared", sout_o, 0);
        rd_status();
        chk("R9 masks untouched by bit3 clear", status_o, 8'h08);

        // R11: serial input in bit 7
        sin = 1; rd_status(); sin = 0;
        chk("R11 serial input bit", status_o, 8'h88);

        // R5: clear beats set
        en_set = 1; en_clr = 1; step(); en_set = 0; en_clr = 0;
        rd_status();
        chk("R5 clear wins", status_o, 8'h00);

        // R13: held strobe over a non-maskable request
        nmi = 1; sample = 1; step(); step(); sample = 0; nmi = 0;
        step(); step();
        chk("R13 single request", n_irq, 8);

        step();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) act=timeout exp=finish");
            summary();
            $finish;
        end
    end

endmodule